// File: doc/BRIEF.md
# Dual-Channel 2x Half-Band Interpolator

This block doubles the sample rate of a pair of 10-bit I/Q streams in front of a dual digital-to-analog converter. It runs on a single output-rate clock and accepts one new I word and one new Q word on every second clock edge, signalled by its own `in_take` strobe. It delivers one filtered output word per channel on every clock edge. The filter is a 43-tap symmetric half-band low-pass with fixed integer coefficients scaled so that the centre tap is 2^14.

The design uses the polyphase form of the filter. On the edges where a sample is taken, the output is the pure-delay phase, which is the input delayed through the centre tap. On the edges in between, the output is the other phase. That phase is built from the eleven non-zero symmetric tap pairs: each pair is summed first, so only eleven multiplies per channel are needed. It is accumulated at full precision, rounded to nearest and clipped to the 10-bit range. Both channels carry identical, independent copies of the datapath.

Top module: `hbi_interp2x`

## Requirements
- R1: `rst` is synchronous and active high. It clears the delay lines and all pipeline registers. On the clock after any reset edge, both outputs read 0. Samples taken before a reset have no effect on any output after it.
- R2: `in_take` is 1 during the first clock after `rst` falls and inverts on every later clock. The inputs are sampled only on edges where `in_take` is 1.
- R3: Inputs and outputs are 10-bit two's complement, with a range of -512 to +511.
- R4: Centre phase. Let x_m be a sample taken on some edge. Directly after that edge, each output equals x_{m-12} of its channel, which is the input delayed by 24 clocks. Samples before the first one after reset count as 0.
- R5: Odd phase. On the following edge, each output equals sat(floor((S + 8192) / 16384)), where S = sum over p = 0..10 of c_p * (x_{m-1-p} + x_{m-22+p}). The coefficients c_0..c_10 are +10, -31, +69, -138, +248, -419, +678, -1083, +1776, -3282, +10364.
- R6: DC gain is exactly one. A constant input held long enough gives that same value on every output clock.
- R7: Rounding is to the nearest integer, with exact halves rounded toward +infinity. For example, a lone input of +1 gives an odd-phase output of +1 (10364/16384), and a lone input of -1 at pair weight -3282 gives 0.
- R8: An odd-phase result above +511 is output as +511, and one below -512 is output as -512. The result never wraps.
- R9: The I and Q channels are independent. A zero input on one channel gives zero on that output, whatever the other channel carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_take | output | 1 | High on the clocks where the input words are sampled |
| i_din | input | 10 | I channel input sample, two's complement |
| q_din | input | 10 | Q channel input sample, two's complement |
| i_dout | output | 10 | I channel output sample, two's complement |
| q_dout | output | 10 | Q channel output sample, two's complement |

## Verification
Rounding and clipping act on the same odd-phase sample. A round-up can push a result that is just inside the range past +511, where it must clip instead of wrap. The bench drives 22-sample full-scale blocks whose signs match every coefficient pair. This drives the sum far past both limits, and a reference model checks each odd-phase output bit-exactly. On a take edge, a new sample enters the delay line while the centre value leaves it. Random streams and a reset in the middle of a stream check that these two updates never disturb each other.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   // Number of symmetric non-zero pairs in the odd polyphase branch.
   localparam int NPAIR  = 11;
   // Coefficient scaling: the centre tap is 2**CSHIFT.
   localparam int CSHIFT = 14;
   // Signed width able to hold any odd-branch coefficient.
   localparam int COEF_W = 16;

   // Odd-branch coefficient for pair p (p = 0 is the outermost pair).
   function automatic int hb_coef(input int p);
      int mag;
      case (p)
         0:       mag = 10;
         1:       mag = 31;
         2:       mag = 69;
         3:       mag = 138;
         4:       mag = 248;
         5:       mag = 419;
         6:       mag = 678;
         7:       mag = 1083;
         8:       mag = 1776;
         9:       mag = 3282;
         default: mag = 10364;
      endcase
      // Signs alternate; the pair nearest the centre is positive.
      return (((NPAIR - 1 - p) % 2) == 0) ? mag : -mag;
   endfunction
endpackage

// File: rtl/hbi_tapline.sv
module hbi_tapline #(
   parameter int DW   = 10,
   parameter int NTAP = 22
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_en,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] taps [NTAP]
);
   if (NTAP < 2) begin : g_bad
      $error("hbi_tapline: NTAP must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NTAP; i++) taps[i] <= '0;
      end else if (shift_en) begin
         taps[0] <= din;
         for (int i = 1; i < NTAP; i++) taps[i] <= taps[i-1];
      end
   end
endmodule

// File: rtl/hbi_mac.sv
module hbi_mac
   import hbi_pkg::*;
#(
   parameter int DW       = 10,
   parameter bit ROUND_EN = 1'b1,
   localparam int NTAP    = 2 * NPAIR
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ld_pre,
   input  logic                 ld_acc,
   input  logic signed [DW-1:0] taps [NTAP],
   output logic signed [DW-1:0] ctr_o,
   output logic signed [DW-1:0] odd_o
);
   localparam int PS_W  = DW + 1;
   localparam int ACC_W = PS_W + COEF_W + 4;

   localparam logic signed [ACC_W-1:0] HALF =
      {{(ACC_W-CSHIFT){1'b0}}, 1'b1, {(CSHIFT-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] MAXV =
      {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV =
      {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

   if (ACC_W <= CSHIFT + DW) begin : g_bad
      $error("hbi_mac: accumulator too narrow");
   end

   logic signed [PS_W-1:0]  ps_q [NPAIR];
   logic signed [ACC_W-1:0] acc_nxt, acc_q, rnd, shf;

   // Stage 1: symmetric pre-add and centre capture
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int p = 0; p < NPAIR; p++) ps_q[p] <= '0;
         ctr_o <= '0;
      end else if (ld_pre) begin
         for (int p = 0; p < NPAIR; p++)
            ps_q[p] <= PS_W'(taps[p]) + PS_W'(taps[NTAP-1-p]);
         ctr_o <= taps[NPAIR];
      end
   end

   // Stage 2: eleven products summed at full precision
   always_comb begin
      acc_nxt = '0;
      for (int p = 0; p < NPAIR; p++)
         acc_nxt = acc_nxt + ACC_W'(ps_q[p]) * ACC_W'(hb_coef(p));
   end

   always_ff @(posedge clk) begin
      if (rst)         acc_q <= '0;
      else if (ld_acc) acc_q <= acc_nxt;
   end

   // Rounding variant chosen at elaboration
   if (ROUND_EN) begin : g_round
      assign rnd = acc_q + HALF;
   end else begin : g_trunc
      assign rnd = acc_q;
   end

   assign shf = rnd >>> CSHIFT;

   always_comb begin
      if (shf > MAXV)      odd_o = MAXV[DW-1:0];
      else if (shf < MINV) odd_o = MINV[DW-1:0];
      else                 odd_o = shf[DW-1:0];
   end
endmodule

// File: rtl/hbi_chan.sv
module hbi_chan
   import hbi_pkg::*;
#(
   parameter int DW       = 10,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 take,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] dout
);
   localparam int NTAP = 2 * NPAIR;

   logic signed [DW-1:0] taps [NTAP];
   logic signed [DW-1:0] ctr, odd;

   hbi_tapline #(.DW(DW), .NTAP(NTAP)) u_line (
      .clk      (clk),
      .rst      (rst),
      .shift_en (take),
      .din      (din),
      .taps     (taps)
   );

   hbi_mac #(.DW(DW), .ROUND_EN(ROUND_EN)) u_mac (
      .clk    (clk),
      .rst    (rst),
      .ld_pre (!take),
      .ld_acc (take),
      .taps   (taps),
      .ctr_o  (ctr),
      .odd_o  (odd)
   );

   // Centre phase on take edges, odd phase on the others
   always_ff @(posedge clk) begin
      if (rst)       dout <= '0;
      else if (take) dout <= ctr;
      else           dout <= odd;
   end
endmodule

// File: rtl/hbi_interp2x.sv
module hbi_interp2x #(
   parameter int DATA_W   = 10,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic              in_take,
   input  logic [DATA_W-1:0] i_din,
   input  logic [DATA_W-1:0] q_din,
   output logic [DATA_W-1:0] i_dout,
   output logic [DATA_W-1:0] q_dout
);
   localparam int NCH = 2;

   if (DATA_W < 4 || DATA_W > 16) begin : g_bad
      $error("hbi_interp2x: DATA_W out of supported range");
   end

   logic                     phase;
   logic signed [DATA_W-1:0] din_a  [NCH];
   logic signed [DATA_W-1:0] dout_a [NCH];

   always_ff @(posedge clk) begin
      if (rst) phase <= 1'b0;
      else     phase <= ~phase;
   end

   assign in_take  = ~phase;
   assign din_a[0] = i_din;
   assign din_a[1] = q_din;
   assign i_dout   = dout_a[0];
   assign q_dout   = dout_a[1];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      hbi_chan #(.DW(DATA_W), .ROUND_EN(ROUND_EN)) u_ch (
         .clk  (clk),
         .rst  (rst),
         .take (in_take),
         .din  (din_a[c]),
         .dout (dout_a[c])
      );
   end
endmodule

// File: rtl/hbi_interp2x_chk.sv
module hbi_interp2x_chk #(
   parameter int DATA_W = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              in_take,
   input logic [DATA_W-1:0] i_din,
   input logic [DATA_W-1:0] q_din,
   input logic [DATA_W-1:0] i_dout,
   input logic [DATA_W-1:0] q_dout
);
   logic [5:0]        cyc, i_run, q_run;
   logic [DATA_W-1:0] i_dcv, q_dcv;

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc   <= '0;
         i_run <= '0;
         q_run <= '0;
         i_dcv <= '0;
         q_dcv <= '0;
      end else begin
         if (cyc != 6'd63) cyc <= cyc + 6'd1;
         if (in_take) begin
            i_dcv <= i_din;
            q_dcv <= q_din;
            if (i_din != i_dcv) i_run <= '0;
            else if (i_run != 6'd63) i_run <= i_run + 6'd1;
            if (q_din != q_dcv) q_run <= '0;
            else if (q_run != 6'd63) q_run <= q_run + 6'd1;
         end
      end
   end

   // R1: outputs are zero on the clock after a reset edge
   a_r1_reset_zero: assert property (@(posedge clk)
      rst |=> (i_dout == '0 && q_dout == '0));

   // R2: the take strobe starts high after reset and then alternates
   a_r2_take_first: assert property (@(posedge clk) disable iff (rst)
      (cyc == 6'd0) |-> in_take);
   a_r2_take_alternates: assert property (@(posedge clk) disable iff (rst)
      (cyc != 6'd0) |-> (in_take != $past(in_take)));

   // R4: the centre phase is the input delayed by 24 clocks
   a_r4_centre_i: assert property (@(posedge clk) disable iff (rst)
      (in_take && cyc >= 6'd26) |=> (i_dout == $past(i_din, 25)));
   a_r4_centre_q: assert property (@(posedge clk) disable iff (rst)
      (in_take && cyc >= 6'd26) |=> (q_dout == $past(q_din, 25)));

   // R6: unity DC gain once the stream has been constant long enough
   a_r6_dc_i: assert property (@(posedge clk) disable iff (rst)
      (i_run >= 6'd40) |-> (i_dout == i_dcv));
   a_r6_dc_q: assert property (@(posedge clk) disable iff (rst)
      (q_run >= 6'd40) |-> (q_dout == q_dcv));
endmodule

bind hbi_interp2x hbi_interp2x_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .in_take (in_take),
   .i_din   (i_din),
   .q_din   (q_din),
   .i_dout  (i_dout),
   .q_dout  (q_dout)
);

// File: tb/sim_hbi_interp2x.sv
module sim_hbi_interp2x;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 20000;
   localparam int HMAX       = 1024;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_take;
   logic [9:0] i_din = '0, q_din = '0;
   logic [9:0] i_dout, q_dout;

   int n_chk  = 0;
   int n_fail = 0;
   int k      = 0;
   int hi [HMAX];
   int hq [HMAX];
   int wd     = 0;

   hbi_interp2x u0 (
      .clk     (clk),
      .rst     (rst),
      .in_take (in_take),
      .i_din   (i_din),
      .q_din   (q_din),
      .i_dout  (i_dout),
      .q_dout  (q_dout)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > WD_LIMIT) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog expired: cycles %0d, limit %0d", wd, WD_LIMIT);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   function automatic int cf(input int p);
      int m [11] = '{10, 31, 69, 138, 248, 419, 678, 1083, 1776, 3282, 10364};
      return ((10 - p) % 2 == 0) ? m[p] : -m[p];
   endfunction

   function automatic int hx(input bit q, input int j);
      if (j < 0) return 0;
      return q ? hq[j] : hi[j];
   endfunction

   // R5 / R7 / R8 reference: odd-phase sample from samples up to index j
   function automatic int odd_ref(input bit q, input int j);
      int s = 0;
      int r;
      for (int p = 0; p < 11; p++)
         s += cf(p) * (hx(q, j - p) + hx(q, j - 21 + p));
      r = (s + 8192) >>> 14;
      if (r > 511)  r = 511;
      if (r < -512) r = -512;
      return r;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (sample %0d)", tag, act, exp, k);
      end
   endtask

   // One input sample on both channels; checks both output phases.
   task automatic step(input int xi, input int xq, input string tag);
      chk("R2 take high", int'(in_take), 1);
      i_din = 10'(xi);
      q_din = 10'(xq);
      hi[k] = xi;
      hq[k] = xq;
      @(posedge clk);
      @(negedge clk);
      chk("R4 centre I", int'($signed(i_dout)), hx(1'b0, k - 12));
      chk("R4 centre Q", int'($signed(q_dout)), hx(1'b1, k - 12));
      chk("R2 take low", int'(in_take), 0);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " odd I"}, int'($signed(i_dout)), odd_ref(1'b0, k - 1));
      chk({tag, " odd Q"}, int'($signed(q_dout)), odd_ref(1'b1, k - 1));
      k++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 reset I", int'($signed(i_dout)), 0);
      chk("R1 reset Q", int'($signed(q_dout)), 0);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      k   = 0;
      for (int j = 0; j < HMAX; j++) begin
         hi[j] = 0;
         hq[j] = 0;
      end
   endtask

   // R8 sign pattern: position d back from a block end gets full scale of
   // the sign of its coefficient pair
   function automatic int fs_val(input int d, input int s);
      bit pos = (d <= 10) ? ((10 - d) % 2 == 0) : ((d - 11) % 2 == 0);
      if (s < 0) pos = !pos;
      return pos ? 511 : -512;
   endfunction

   initial begin
      int seed_v;
      seed_v = int'($urandom(32'd20240917));
      for (int j = 0; j < HMAX; j++) begin
         hi[j] = 0;
         hq[j] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset I", int'($signed(i_dout)), 0);
      chk("R1 reset Q", int'($signed(q_dout)), 0);
      rst = 1'b0;

      // R7: unit impulses show round-to-nearest on small products
      step(1, -1, "R7");
      for (int j = 0; j < 29; j++) step(0, 0, "R7");

      // R5: impulse response reveals every coefficient and sign
      step(256, -512, "R5");
      for (int j = 0; j < 29; j++) step(0, 0, "R5");

      // R6: DC steps, then hold
      for (int j = 0; j < 60; j++) step(300, -200, "R6");
      for (int j = 0; j < 30; j++) step(-512, 511, "R6");

      // R8: matched full-scale blocks drive the sum past both limits
      for (int b = 0; b < 4; b++)
         for (int j = 0; j < 22; j++)
            step(fs_val(21 - j, (b % 2 == 0) ? 1 : -1),
                 fs_val(21 - j, (b % 2 == 0) ? -1 : 1), "R8");
      for (int j = 0; j < 24; j++) step(0, 0, "R8");

      // R9: I busy, Q silent
      for (int j = 0; j < 60; j++)
         step(int'($urandom_range(1023)) - 512, 0, "R9");

      // R3: random two's complement streams on both channels
      for (int j = 0; j < 300; j++)
         step(int'($urandom_range(1023)) - 512,
              int'($urandom_range(1023)) - 512, "R3");

      // R1: reset mid-stream, then zeros must give zeros
      do_reset();
      for (int j = 0; j < 30; j++) step(0, 0, "R1");
      for (int j = 0; j < 40; j++)
         step(int'($urandom_range(1023)) - 512,
              int'($urandom_range(1023)) - 512, "R5");

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule